// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the address for a four-beat burst into a synchronous memory. A start strobe captures an external address. Only the lowest two bits of that address are then sequenced: each cycle with the advance strobe high moves the burst to its next beat, and each cycle with advance low holds the current beat. This lets a controller insert wait states without losing its place. The upper address bits are captured together with the start strobe and passed to the output unchanged until the next start.

The order of the four beats is set by a configuration input that is sampled only while reset is asserted. In linear order the low bits count up from the starting pair and wrap within the group of four. In interleaved order the low bits are the starting pair XORed with the beat number, which is the order some cache-line fills expect. A beat index output reports how many steps have been taken since the last start. Chip-select decoding and data-path control belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `addr_o` and `beat_o` become zero after that edge, and they stay zero after reset ends until a start or an advance is sampled.
- R2: A rising edge with `load_i` high makes `addr_o` equal to the `addr_i` sampled at that edge and sets `beat_o` to 0. Both changes are visible after that edge.
- R3: A rising edge with `step_i` high and `load_i` low increments `beat_o` by one modulo 4, so beat 3 is followed by beat 0.
- R4: A rising edge with both `load_i` and `step_i` low leaves `addr_o` and `beat_o` unchanged.
- R5: In linear order (order select value 0), `addr_o[1:0]` equals (start pair + `beat_o`) modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R6: In interleaved order (order select value 1), `addr_o[1:0]` equals the start pair XOR `beat_o`. For example, a start of 2 gives 2, 3, 0, 1, and a start of 1 gives 1, 0, 3, 2.
- R7: When `load_i` and `step_i` are both high at the same edge, the start wins: the result matches R2 and the beat does not advance.
- R8: `addr_o[ADDR_W-1:2]` always equals the upper bits captured at the last start. A wrap of the low bits never carries into them.
- R9: The order is the value of `mode_i` at the last rising edge with `rst_n` low. Changes of `mode_i` while out of reset have no effect on `addr_o`.
- R10: Changes of `addr_i` at edges with `load_i` low have no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset. The order select is sampled while it is low |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| load_i | input | 1 | Start strobe. Captures `addr_i` and restarts the beat count |
| step_i | input | 1 | Advance strobe. High steps to the next beat, low holds |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index since the last start |

## Verification
Every result in this block is one register away from its cause. The start capture, a beat step or a hold decided at a rising edge is visible on `addr_o` and `beat_o` from just after that edge. The order select, however, is frozen at the last edge of reset. The bench drives its inputs at the falling edge and updates a behavioural model right after the next rising edge from the values it drove itself. It then compares both outputs against that model at the following falling edge, so each comparison looks at exactly the cycle in which the result is due.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_order_latch.sv
module burst_order_latch
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  output burst_order_e order_o
);
  burst_order_e order_q;

  // Sampled on every edge in reset; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) order_q <= burst_order_e'(mode_i);
  end

  assign order_o = order_q;

  // R9: the order never moves once reset has been released.
  a_r9_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(order_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  output logic [CW-1:0] beat_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_q + ONE;
  end

  assign beat_o = beat_q;

  // R2 / R7: a start clears the beat, even with an advance on the same edge.
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> beat_o == '0);
  // R3: an advance steps the beat by one, modulo the group size.
  a_r3_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_i) |=> beat_o == $past(beat_o) + ONE);
  // R4: no strobe, no motion.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int CW = 2
) (
  input  burst_order_e  order_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] beat_i,
  output logic [CW-1:0] low_o
);
  logic [CW-1:0] ilv;
  logic [CW-1:0] lin;

  for (genvar b = 0; b < CW; b++) begin : g_ilv
    assign ilv[b] = start_i[b] ^ beat_i[b];
  end

  assign lin   = start_i + beat_i;
  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LOW_W-1:0]  beat_o
);
  localparam int UP_W = ADDR_W - LOW_W;

  burst_order_e     order;
  logic [LOW_W-1:0] start_q;
  logic [UP_W-1:0]  upper_q;
  logic [LOW_W-1:0] beat;
  logic [LOW_W-1:0] low;

  burst_order_latch u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .order_o (order)
  );

  burst_beat_ctr #(.CW(LOW_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .step_i (step_i),
    .beat_o (beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
    end else if (load_i) begin
      start_q <= addr_i[LOW_W-1:0];
      upper_q <= addr_i[ADDR_W-1:LOW_W];
    end
  end

  burst_order_map #(.CW(LOW_W)) u_map (
    .order_i (order),
    .start_i (start_q),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign addr_o = {upper_q, low};
  assign beat_o = beat;

  // R2: a start shows the captured address unchanged on the next cycle.
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(addr_i));
  // R8 / R10: the upper bits only move on a start.
  a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:LOW_W]));
  // R4: with no strobe the whole address holds.
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int LOW_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic load_i = 1'b0;
  logic step_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [LOW_W-1:0]  beat_o;

  int total = 0;
  int bad = 0;
  int m_start = 0, m_cnt = 0, m_upper = 0, m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .load_i(load_i),
    .step_i(step_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [ADDR_W-1:0] exp_addr();
    int low;
    if (m_mode != 0) low = m_start ^ m_cnt;
    else             low = (m_start + m_cnt) % 4;
    return ADDR_W'(m_upper * 4 + low);
  endfunction

  task automatic check(input string tag);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr();
    total++;
    if (addr_o !== ea || beat_o !== LOW_W'(m_cnt)) begin
      bad++;
      $display("FAIL %s addr=%h exp=%h beat=%0d exp=%0d", tag, addr_o, ea, beat_o, m_cnt);
    end
  endtask

  // Drive at the falling edge, update the model after the rising edge, compare at the next falling edge.
  task automatic tick(input logic ld, input logic st, input logic [ADDR_W-1:0] a, input string tag);
    load_i = ld; step_i = st; addr_i = a;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_start = 0; m_cnt = 0; m_upper = 0; m_mode = int'(mode_i);
    end else if (ld) begin
      m_start = int'(a) % 4; m_upper = int'(a) / 4; m_cnt = 0;
    end else if (st) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_i = m;
    tick(1'b0, 1'b1, 17'h1FFFF, "R1");
    tick(1'b1, 1'b0, 17'h0ABCD, "R1");
    rst_n = 1'b1;
    tick(1'b0, 1'b0, 17'h12345, "R1");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Linear order
    do_reset(1'b0);
    tick(1'b1, 1'b0, 17'h15A3E, "R2");
    tick(1'b0, 1'b1, 17'h00000, "R5");
    tick(1'b0, 1'b1, 17'h00001, "R8");   // wrap 3 -> 0 in low bits, no carry
    tick(1'b0, 1'b0, 17'h1FFFF, "R10");
    tick(1'b0, 1'b0, 17'h00003, "R4");
    tick(1'b0, 1'b1, 17'h0F0F0, "R3");
    tick(1'b0, 1'b1, 17'h0F0F1, "R3");  // beat 3 -> 0
    tick(1'b0, 1'b1, 17'h0F0F2, "R5");
    tick(1'b1, 1'b1, 17'h00005, "R7");
    tick(1'b0, 1'b1, 17'h00006, "R5");
    for (int s = 0; s < 4; s++) begin
      tick(1'b1, 1'b0, ADDR_W'(17'h0C000 + s), "R5");
      for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, 17'h00000, "R5");
    end
    // Interleaved order, then move mode_i while running
    do_reset(1'b1);
    mode_i = 1'b0;
    tick(1'b0, 1'b0, 17'h00000, "R9");
    for (int s = 0; s < 4; s++) begin
      tick(1'b1, 1'b0, ADDR_W'(17'h1B3C4 + s), "R6");
      for (int k = 0; k < 4; k++) begin
        tick(1'b0, 1'b1, 17'h00000, "R6");
        tick(1'b0, 1'b0, 17'h1FFFF, "R4");
      end
    end
    mode_i = 1'b1;
    tick(1'b1, 1'b1, 17'h00002, "R7");
    mode_i = 1'b0;
    tick(1'b0, 1'b1, 17'h00000, "R9");
    tick(1'b0, 1'b1, 17'h00000, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule